// File: doc/BRIEF.md
# Tagged Receive Character Queue

This block sits behind the bit-level receiver of a high-speed serial port (8 data bits, no parity, one stop bit). The receiver front end hands it one deserialized character at a time, with a framing-error flag and a break flag. Each character is kept together with its two flags in a first-in, first-out store of 64 entries. Software or a bus bridge drains the store through a read port. Each read request pops one entry, and the word on the port always shows the oldest entry.

The block also produces three signals from the fill level. The first is a trigger request, raised when the level reaches a programmed threshold. The second is an inactivity timeout request, raised after a programmed number of character times pass with data waiting and no traffic. The third is a hardware flow-control output (RTS) that tells the far end to pause once the level reaches a second, separate threshold. A level word reports the receive fill level, with the transmit-side level, supplied from outside, packed next to it.

The timeout logic is a three-state machine. In IDLE no count runs. This state is entered when the timeout is disabled, or when the queue is empty and nothing is being written. In COUNT the machine counts character-time ticks. In FIRED the timeout request is raised. The transitions are:
- IDLE→COUNT: the queue holds data or is being written while the timeout is enabled.
- COUNT→COUNT with the count cleared ("restart"): a character is written or popped.
- COUNT→FIRED: the tick count reaches the programmed limit.
- FIRED→COUNT: a write or pop occurs.
- Any state→IDLE: the timeout is disabled or the queue is empty.

Top module: `rx_tag_fifo`

## Requirements
- R1: `rd_word` shows the oldest stored entry: bits 7:0 hold the character, bit 9 its framing-error flag, bit 10 its break flag, and bit 8 is 0. Entries come out in arrival order, one per cycle in which `rd_req` is high and the queue is non-empty.
- R2: `level_word` bits 7:0 hold the number of stored entries (0 to 64). Bits 15:8 repeat `tx_level` unchanged.
- R3: The queue holds 64 entries. A character offered while the level is 64 is discarded, even if a read is accepted in the same cycle, and `overrun` pulses high for exactly one cycle, the cycle after the offer.
- R4: With the queue empty, `rd_word` equals 0x100 (only bit 8 set). A read request then leaves the level and the following data unchanged.
- R5: `trig_req` is high exactly while the level is at or above the threshold selected by `trig_code`. The codes are 0→1, 1→4, 2→8, 3→16, 4→32 and 5→48 characters, and codes 6 and 7 behave as 48.
- R6: `tmo_code` selects the timeout: 0 disables it, and 1, 2 and 3 select 4, 8 and 16 `char_tick` pulses. `tmo_req` rises on the clock edge that samples the limit-th tick received while the queue is non-empty with no write or pop. It stays high until a write, a pop, an empty queue or code 0 clears it on the next edge.
- R7: A write or a pop clears the tick count, so the limit must be counted again from zero after it.
- R8: When `rts_en` is 1, a stop condition holds while the level is at or above 8, 16, 32 or 48 for `rts_code` 0, 1, 2 and 3. When `rts_en` is 0 the stop condition never holds. `rts_out` equals the stop condition XOR `rts_inv`.
- R9: After reset the level is 0, `rd_word` is 0x100, and `trig_req`, `tmo_req` and `overrun` are 0.
- R10: A write and a read accepted in the same cycle (queue neither empty nor full) leave the level unchanged. The popped entry leaves and the new one is appended.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| char_valid | input | 1 | Front end offers a character this cycle |
| char_data | input | 8 | Offered character |
| char_ferr | input | 1 | Framing error seen on the offered character |
| char_brk | input | 1 | Offered character is a break condition |
| char_tick | input | 1 | One pulse per character time |
| rd_req | input | 1 | Pop the oldest entry |
| tx_level | input | 8 | Transmit fill level, reported in the level word |
| trig_code | input | 3 | Trigger threshold code |
| tmo_code | input | 2 | Inactivity timeout code |
| rts_code | input | 2 | Flow-control threshold code |
| rts_en | input | 1 | Enable automatic flow control |
| rts_inv | input | 1 | Invert the flow-control output |
| rd_word | output | 11 | Oldest entry with flags and empty bit |
| level_word | output | 16 | Transmit level (15:8) and receive level (7:0) |
| trig_req | output | 1 | Fill threshold reached |
| tmo_req | output | 1 | Inactivity timeout reached |
| overrun | output | 1 | One-cycle pulse: character dropped while full |
| rts_out | output | 1 | Flow-control output |

## Verification
The hardest situation to reach is the timeout edge. A tick count has to be interrupted by a pop one tick short of the limit, and the restart must then be seen to need the full limit again. The stimulus places tick pulses on chosen cycles against a partly filled queue and inserts a pop at a known tick count. Reaching the overflow path requires filling all 64 entries first. The fill loop therefore sweeps the trigger and flow-control codes and the inversion bit on the way up, so every threshold is crossed during a single fill.

// File: rtl/rx_tag_pkg.sv
package rx_tag_pkg;

    typedef enum logic [1:0] {
        TMO_IDLE  = 2'd0,
        TMO_COUNT = 2'd1,
        TMO_FIRED = 2'd2
    } tmo_state_e;

    typedef struct packed {
        logic       brk;
        logic       ferr;
        logic [7:0] data;
    } rx_entry_t;

    function automatic int trig_thresh(input logic [2:0] code);
        case (code)
            3'd0:    return 1;
            3'd1:    return 4;
            3'd2:    return 8;
            3'd3:    return 16;
            3'd4:    return 32;
            default: return 48;
        endcase
    endfunction

    function automatic int flow_thresh(input logic [1:0] code);
        case (code)
            2'd0:    return 8;
            2'd1:    return 16;
            2'd2:    return 32;
            default: return 48;
        endcase
    endfunction

    function automatic logic [4:0] tmo_limit(input logic [1:0] code);
        case (code)
            2'd1:    return 5'd4;
            2'd2:    return 5'd8;
            2'd3:    return 5'd16;
            default: return 5'd0;
        endcase
    endfunction

endpackage

// File: rtl/rx_tag_store.sv
module rx_tag_store
    import rx_tag_pkg::*;
#(
    parameter int DEPTH = 64,
    localparam int AW = $clog2(DEPTH),
    localparam int CW = $clog2(DEPTH + 1)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            wr_en,
    input  rx_entry_t       wr_entry,
    input  logic            rd_en,
    output rx_entry_t       head,
    output logic [CW-1:0]   count
);

    rx_entry_t         mem [DEPTH];
    logic [AW-1:0]     wptr;
    logic [AW-1:0]     rptr;

    function automatic logic [AW-1:0] bump(input logic [AW-1:0] p);
        return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    always_ff @(posedge clk) begin
        if (wr_en) mem[wptr] <= wr_entry;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wptr  <= '0;
            rptr  <= '0;
            count <= '0;
        end else begin
            if (wr_en) wptr <= bump(wptr);
            if (rd_en) rptr <= bump(rptr);
            unique case ({wr_en, rd_en})
                2'b10:   count <= count + 1'b1;
                2'b01:   count <= count - 1'b1;
                default: count <= count;
            endcase
        end
    end

    assign head = mem[rptr];

endmodule

// File: rtl/rx_tag_idle.sv
module rx_tag_idle
    import rx_tag_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic [1:0] code,
    input  logic       empty,
    input  logic       wr_acc,
    input  logic       rd_acc,
    input  logic       tick,
    output logic       tmo_req
);

    tmo_state_e  st, st_n;
    logic [4:0]  cnt, cnt_n;
    logic [4:0]  lim;

    assign lim = tmo_limit(code);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st  <= TMO_IDLE;
            cnt <= '0;
        end else begin
            st  <= st_n;
            cnt <= cnt_n;
        end
    end

    always_comb begin
        st_n  = st;
        cnt_n = cnt;
        if (code == 2'd0 || (empty && !wr_acc)) begin
            st_n  = TMO_IDLE;
            cnt_n = '0;
        end else if (wr_acc || rd_acc) begin
            st_n  = TMO_COUNT;
            cnt_n = '0;
        end else begin
            unique case (st)
                TMO_IDLE: begin
                    st_n  = TMO_COUNT;
                    cnt_n = '0;
                end
                TMO_COUNT: begin
                    if (tick) begin
                        if (cnt == lim - 5'd1) st_n  = TMO_FIRED;
                        else                   cnt_n = cnt + 5'd1;
                    end
                end
                TMO_FIRED: st_n = TMO_FIRED;
                default:   st_n = TMO_IDLE;
            endcase
        end
    end

    always_comb begin
        tmo_req = (st == TMO_FIRED);
    end

endmodule

// File: rtl/rx_tag_fifo.sv
module rx_tag_fifo
    import rx_tag_pkg::*;
#(
    parameter int DEPTH = 64,
    localparam int CW = $clog2(DEPTH + 1)
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        char_valid,
    input  logic [7:0]  char_data,
    input  logic        char_ferr,
    input  logic        char_brk,
    input  logic        char_tick,
    input  logic        rd_req,
    input  logic [7:0]  tx_level,
    input  logic [2:0]  trig_code,
    input  logic [1:0]  tmo_code,
    input  logic [1:0]  rts_code,
    input  logic        rts_en,
    input  logic        rts_inv,
    output logic [10:0] rd_word,
    output logic [15:0] level_word,
    output logic        trig_req,
    output logic        tmo_req,
    output logic        overrun,
    output logic        rts_out
);

    logic [CW-1:0] count;
    rx_entry_t     head;
    rx_entry_t     in_entry;
    logic          full, empty, wr_acc, rd_acc, flow_stop;

    assign full     = (int'(count) == DEPTH);
    assign empty    = (count == '0);
    assign wr_acc   = char_valid && !full;
    assign rd_acc   = rd_req && !empty;
    assign in_entry = '{brk: char_brk, ferr: char_ferr, data: char_data};

    rx_tag_store #(.DEPTH(DEPTH)) u_store (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (wr_acc),
        .wr_entry (in_entry),
        .rd_en    (rd_acc),
        .head     (head),
        .count    (count)
    );

    rx_tag_idle u_idle (
        .clk     (clk),
        .rst_n   (rst_n),
        .code    (tmo_code),
        .empty   (empty),
        .wr_acc  (wr_acc),
        .rd_acc  (rd_acc),
        .tick    (char_tick),
        .tmo_req (tmo_req)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) overrun <= 1'b0;
        else        overrun <= char_valid && full;
    end

    always_comb begin
        rd_word    = empty ? 11'h100 : {head.brk, head.ferr, 1'b0, head.data};
        level_word = {tx_level, 8'(count)};
        trig_req   = int'(count) >= trig_thresh(trig_code);
        flow_stop  = rts_en && (int'(count) >= flow_thresh(rts_code));
        rts_out    = flow_stop ^ rts_inv;
    end

endmodule

// File: rtl/rx_tag_fifo_chk.sv
module rx_tag_fifo_chk #(
    parameter int DEPTH = 64
) (
    input logic        clk,
    input logic        rst_n,
    input logic        char_valid,
    input logic        rd_req,
    input logic        rts_en,
    input logic        rts_inv,
    input logic [10:0] rd_word,
    input logic [15:0] level_word,
    input logic        tmo_req,
    input logic        overrun,
    input logic        rts_out
);

    logic [7:0] lvl;
    assign lvl = level_word[7:0];

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        int'(lvl) <= DEPTH); // R3

    AST_FULL_DROP: assert property (@(posedge clk) disable iff (!rst_n)
        (char_valid && int'(lvl) == DEPTH && !rd_req) |=> (int'(lvl) == DEPTH && overrun)); // R3

    AST_EMPTY_WORD: assert property (@(posedge clk) disable iff (!rst_n)
        (lvl == 8'd0) |-> (rd_word == 11'h100)); // R4

    AST_EMPTY_READ: assert property (@(posedge clk) disable iff (!rst_n)
        (lvl == 8'd0 && rd_req && !char_valid) |=> (lvl == 8'd0)); // R4

    AST_TMO_DATA: assert property (@(posedge clk) disable iff (!rst_n)
        tmo_req |-> (lvl != 8'd0)); // R6

    AST_FLOW_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        !rts_en |-> (rts_out == rts_inv)); // R8

    AST_RW_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
        (char_valid && rd_req && lvl != 8'd0 && int'(lvl) != DEPTH) |=> $stable(lvl)); // R10

endmodule

bind rx_tag_fifo rx_tag_fifo_chk #(.DEPTH(DEPTH)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .char_valid (char_valid),
    .rd_req     (rd_req),
    .rts_en     (rts_en),
    .rts_inv    (rts_inv),
    .rd_word    (rd_word),
    .level_word (level_word),
    .tmo_req    (tmo_req),
    .overrun    (overrun),
    .rts_out    (rts_out)
);

// File: tb/rx_tag_fifo_test.sv
module rx_tag_fifo_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        char_valid = 0, char_ferr = 0, char_brk = 0, char_tick = 0, rd_req = 0;
    logic [7:0]  char_data = 0, tx_level = 0;
    logic [2:0]  trig_code = 0;
    logic [1:0]  tmo_code = 0, rts_code = 0;
    logic        rts_en = 0, rts_inv = 0;
    logic [10:0] rd_word;
    logic [15:0] level_word;
    logic        trig_req, tmo_req, overrun, rts_out;

    int compared = 0;
    int mismatched = 0;
    bit done = 0;

    // behavioural reference state
    logic [10:0] q[$];
    bit m_ovr = 0, m_run = 0, m_fired = 0;
    int m_ticks = 0;

    always #5 clk = ~clk;

    rx_tag_fifo uut (
        .clk(clk), .rst_n(rst_n), .char_valid(char_valid), .char_data(char_data),
        .char_ferr(char_ferr), .char_brk(char_brk), .char_tick(char_tick),
        .rd_req(rd_req), .tx_level(tx_level), .trig_code(trig_code),
        .tmo_code(tmo_code), .rts_code(rts_code), .rts_en(rts_en), .rts_inv(rts_inv),
        .rd_word(rd_word), .level_word(level_word), .trig_req(trig_req),
        .tmo_req(tmo_req), .overrun(overrun), .rts_out(rts_out)
    );

    task automatic chk(input string tag, input int act, input int exp);
        compared++;
        if (act != exp) begin
            mismatched++;
            $display("FAIL %s actual=0x%0h expected=0x%0h at %0t", tag, act, exp, $time);
        end
    endtask

    function automatic int ref_trig(input int c);
        int t[8] = '{1, 4, 8, 16, 32, 48, 48, 48};
        return t[c];
    endfunction

    function automatic int ref_flow(input int c);
        int t[4] = '{8, 16, 32, 48};
        return t[c];
    endfunction

    function automatic int ref_lim(input int c);
        return (c == 0) ? 0 : (2 << c);
    endfunction

    task automatic compare_all();
        int n = q.size();
        chk("R1 rd_word", rd_word, (n > 0) ? q[0] : 11'h100);
        chk("R2 level_word", level_word, {tx_level, 8'(n)});
        chk("R3 overrun", overrun, m_ovr);
        chk("R5 trig_req", trig_req, n >= ref_trig(trig_code));
        chk("R6 tmo_req", tmo_req, m_fired);
        chk("R8 rts_out", rts_out, (rts_en && n >= ref_flow(rts_code)) ^ rts_inv);
    endtask

    task automatic update_model();
        int  n  = q.size();
        bit  wr = char_valid && n < 64;
        bit  rd = rd_req && n > 0;
        m_ovr = char_valid && n == 64;
        if (tmo_code == 0 || (n == 0 && !wr)) begin
            m_run = 0; m_ticks = 0; m_fired = 0;
        end else if (wr || rd) begin
            m_run = 1; m_ticks = 0; m_fired = 0;
        end else if (!m_run) begin
            m_run = 1; m_ticks = 0;
        end else if (!m_fired && char_tick) begin
            m_ticks++;
            if (m_ticks == ref_lim(tmo_code)) m_fired = 1;
        end
        if (rd) void'(q.pop_front());
        if (wr) q.push_back({char_brk, char_ferr, 1'b0, char_data});
    endtask

    task automatic step(input bit v, input logic [7:0] d, input bit fe, input bit bk,
                        input bit rd, input bit tk);
        char_valid = v; char_data = d; char_ferr = fe; char_brk = bk;
        rd_req = rd; char_tick = tk;
        #1;
        compare_all();
        @(posedge clk);
        update_model();
        @(negedge clk);
        char_valid = 0; rd_req = 0; char_tick = 0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #1;
        // R9 reset state
        chk("R9 level", level_word[7:0], 0);
        chk("R9 rd_word", rd_word, 11'h100);
        chk("R9 trig", trig_req, 0);
        chk("R9 tmo", tmo_req, 0);
        chk("R9 overrun", overrun, 0);
        @(negedge clk);
        tx_level = 8'h2A;

        // R4 read while empty
        step(0, 8'h00, 0, 0, 1, 0);
        #1;
        chk("R4 level after empty read", level_word[7:0], 0);
        chk("R4 word after empty read", rd_word, 11'h100);
        @(negedge clk);

        // R1 flagged characters in and out
        step(1, 8'h41, 0, 0, 0, 0);
        step(1, 8'h00, 1, 0, 0, 0);
        step(1, 8'h00, 0, 1, 0, 0);
        step(1, 8'hFE, 1, 1, 0, 0);
        for (int i = 0; i < 4; i++) step(0, 8'h00, 0, 0, 1, 0);

        // fill to capacity while sweeping R5 / R8 codes
        rts_en = 1;
        for (int i = 0; i < 64; i++) begin
            trig_code = 3'(i % 8);
            rts_code  = 2'(i / 16);
            rts_inv   = i[3];
            if (i == 40) tx_level = 8'hC3;
            step(1, 8'(i * 7 + 3), (i % 5) == 0, (i % 11) == 0, 0, 0);
        end
        trig_code = 3'd5; rts_code = 2'd3; rts_inv = 0;
        // R3 overflow: dropped, overrun one cycle later
        step(1, 8'hEE, 0, 0, 0, 0);
        step(1, 8'hEF, 0, 0, 1, 0);
        step(0, 8'h00, 0, 0, 0, 0);
        #1;
        chk("R3 level stays after drop", level_word[7:0], 63);
        @(negedge clk);

        // R10 simultaneous read and write
        for (int i = 0; i < 8; i++) begin
            step(1, 8'(8'h90 + i), 0, i[0], 1, 0);
            #1;
            chk("R10 level unchanged", level_word[7:0], 63);
            @(negedge clk);
        end
        rts_en = 0; rts_inv = 1;
        for (int i = 0; i < 70; i++) begin
            trig_code = 3'(i % 8);
            step(0, 8'h00, 0, 0, 1, 0);
        end

        // R6 / R7 inactivity timeout
        rts_inv = 0;
        tmo_code = 2'd1;
        step(1, 8'h31, 0, 0, 0, 0);
        step(1, 8'h32, 0, 0, 0, 0);
        for (int i = 0; i < 4; i++) begin
            step(0, 8'h00, 0, 0, 0, 1);
            step(0, 8'h00, 0, 0, 0, 0);
        end
        #1;
        chk("R6 fired after 4 ticks", tmo_req, 1);
        @(negedge clk);
        step(0, 8'h00, 0, 0, 1, 0);
        for (int i = 0; i < 3; i++) begin
            step(0, 8'h00, 0, 0, 0, 1);
            step(0, 8'h00, 0, 0, 0, 0);
        end
        #1;
        chk("R7 restart needs full limit", tmo_req, 0);
        @(negedge clk);
        step(0, 8'h00, 0, 0, 0, 1);
        #1;
        chk("R7 fires on 4th tick after restart", tmo_req, 1);
        @(negedge clk);
        for (int c = 2; c < 4; c++) begin
            tmo_code = 2'(c);
            step(1, 8'(c), 0, 0, 0, 0);
            for (int i = 0; i < 17; i++) begin
                step(0, 8'h00, 0, 0, 0, 1);
                step(0, 8'h00, 0, 0, 0, 0);
            end
        end
        tmo_code = 2'd0;
        for (int i = 0; i < 20; i++) step(0, 8'h00, 0, 0, 0, 1);
        #1;
        chk("R6 disabled code", tmo_req, 0);
        @(negedge clk);
        for (int i = 0; i < 4; i++) step(0, 8'h00, 0, 0, 1, 0);

        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            compared++;
            mismatched++;
            $display("FAIL all-requirements watchdog actual=running expected=finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
            $finish;
        end
    end

endmodule